// File: doc/BRIEF.md
# Dual-Mode Fixed-Point Add/Subtract Status Unit

This unit adds or subtracts two 64-bit operands and derives carry, overflow and a 4-bit condition field from the outcome. The arithmetic always runs across all 64 bits. A mode input only chooses whether the status comes from the top of the full word (bit 63) or from the low word (bit 31). Subtraction forms `op_b_i - op_a_i` as the inverted first operand plus the second operand plus one, so a carry of one means no borrow occurred.

Carry, overflow and a sticky summary-overflow flag live in a local 64-bit exception register. They change only when the operation asks for a status update. The condition field is registered and changes only on recording operations. Software can load the exception register directly, and that write is the only way to clear the sticky flag. The result output is combinational; the status is registered on the rising clock edge.

Top module: `fxu_status_unit`

## Requirements
- R1: `result_o` equals `op_a_i + op_b_i` when `sub_i`=0 and `op_b_i - op_a_i` when `sub_i`=1, computed over all 64 bits in both modes.
- R2: With `mode32_i`=0 and `status_en_i`=1, xer bit 29 (CA) takes the carry out of bit 63, and xer bit 30 (OV) takes the signed 64-bit overflow.
- R3: With `mode32_i`=1 and `status_en_i`=1, CA takes the carry out of bit 31, and OV takes the signed overflow of the low 32 bits.
- R4: For subtraction, CA is 1 exactly when `op_b_i >= op_a_i` as unsigned values over the active width (no borrow).
- R5: With `status_en_i`=0 and `xer_wdata_i` not written, the whole of `xer_o` holds its value.
- R6: xer bit 31 (SO) is set whenever OV is set by an update. Only a write through `xer_we_i` clears it.
- R7: With `rec_i`=1, `cr_o` is loaded as {neg[3], pos[2], zero[1], so[0]}. The sign and zero tests treat the result as signed over the active width (64 or low 32 bits). Exactly one of bits 3..1 is set, and bit 0 equals the SO value after the same edge.
- R8: With `rec_i`=0, `cr_o` holds its value.
- R9: `xer_we_i`=1 loads all 64 bits of `xer_wdata_i` into the exception register. In the same cycle this write takes priority over a status update.
- R10: While `rst_ni` is low, `xer_o` and `cr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_a_i | input | 64 | First operand (inverted for subtract) |
| op_b_i | input | 64 | Second operand |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| mode32_i | input | 1 | 1 derives status from the low 32 bits |
| status_en_i | input | 1 | Update CA, OV and SO |
| rec_i | input | 1 | Record the condition field |
| xer_we_i | input | 1 | Load the exception register |
| xer_wdata_i | input | 64 | Data for the exception register load |
| result_o | output | 64 | Combinational 64-bit result |
| xer_o | output | 64 | Exception register (SO bit 31, OV bit 30, CA bit 29) |
| cr_o | output | 4 | Recorded condition field |

## Verification
On every cycle the assertions check the following:
- holding of the exception register and the condition field when no update is requested;
- stickiness of SO;
- that OV implies SO;
- that a recorded field has exactly one of neg, pos and zero set, with its SO bit matching the register;
- that an explicit write lands verbatim.

The arithmetic values of carry and overflow, and the way they switch between bit 63 and bit 31 with the mode, can only be shown by the bench. It runs directed scenarios at 0x7FFFFFFF, 0xFFFFFFFF and 2^63-1 in both modes against an independent wide-integer model.

// File: rtl/fxu_pkg.sv
package fxu_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned HLEN   = 32;
  localparam int unsigned CR_W   = 4;
  localparam int unsigned SO_BIT = 31;
  localparam int unsigned OV_BIT = 30;
  localparam int unsigned CA_BIT = 29;

  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
    logic so;
  } cr_field_t;

  typedef struct packed {
    logic ca;
    logic ov;
    logic neg;
    logic zero;
  } flags_t;
endpackage

// File: rtl/fxu_adder.sv
module fxu_adder #(
  parameter int unsigned W  = 64,
  parameter int unsigned HW = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ca_full_o,
  output logic         ov_full_o,
  output logic         ca_half_o,
  output logic         ov_half_o
);
  logic [W-1:0] x;
  logic [W:0]   acc;

  always_comb begin
    x   = sub_i ? ~a_i : a_i;
    acc = {1'b0, x} + {1'b0, b_i} + {{W{1'b0}}, sub_i};
  end

  assign sum_o     = acc[W-1:0];
  assign ca_full_o = acc[W];
  // carry into bit HW is the carry out of the low half
  assign ca_half_o = acc[HW] ^ x[HW] ^ b_i[HW];
  assign ov_full_o = (x[W-1] == b_i[W-1]) && (acc[W-1] != x[W-1]);
  assign ov_half_o = (x[HW-1] == b_i[HW-1]) && (acc[HW-1] != x[HW-1]);
endmodule

// File: rtl/fxu_status_sel.sv
module fxu_status_sel
  import fxu_pkg::*;
#(
  parameter int unsigned W  = 64,
  parameter int unsigned HW = 32
) (
  input  logic [W-1:0] sum_i,
  input  logic         mode32_i,
  input  logic         ca_full_i,
  input  logic         ov_full_i,
  input  logic         ca_half_i,
  input  logic         ov_half_i,
  output flags_t       flags_o
);
  logic zero_full, zero_half;

  assign zero_full = (sum_i == '0);
  assign zero_half = (sum_i[HW-1:0] == '0);

  always_comb begin
    if (mode32_i) begin
      flags_o.ca   = ca_half_i;
      flags_o.ov   = ov_half_i;
      flags_o.neg  = sum_i[HW-1];
      flags_o.zero = zero_half;
    end else begin
      flags_o.ca   = ca_full_i;
      flags_o.ov   = ov_full_i;
      flags_o.neg  = sum_i[W-1];
      flags_o.zero = zero_full;
    end
  end
endmodule

// File: rtl/fxu_state.sv
module fxu_state
  import fxu_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  flags_t       flags_i,
  input  logic         status_en_i,
  input  logic         rec_i,
  input  logic         xer_we_i,
  input  logic [W-1:0] xer_wdata_i,
  output logic [W-1:0] xer_o,
  output cr_field_t    cr_o
);
  logic [W-1:0] xer_q, xer_d;
  cr_field_t    cr_q, cr_d;

  always_comb begin
    xer_d = xer_q;
    if (xer_we_i) begin
      xer_d = xer_wdata_i;
    end else if (status_en_i) begin
      xer_d[CA_BIT] = flags_i.ca;
      xer_d[OV_BIT] = flags_i.ov;
      xer_d[SO_BIT] = xer_q[SO_BIT] | flags_i.ov;
    end
  end

  always_comb begin
    cr_d = cr_q;
    if (rec_i) begin
      cr_d.neg  = flags_i.neg;
      cr_d.zero = flags_i.zero;
      cr_d.pos  = ~flags_i.neg & ~flags_i.zero;
      cr_d.so   = xer_d[SO_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xer_q <= '0;
      cr_q  <= '0;
    end else begin
      xer_q <= xer_d;
      cr_q  <= cr_d;
    end
  end

  assign xer_o = xer_q;
  assign cr_o  = cr_q;
endmodule

// File: rtl/fxu_status_unit.sv
module fxu_status_unit
  import fxu_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned HW = HLEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         sub_i,
  input  logic         mode32_i,
  input  logic         status_en_i,
  input  logic         rec_i,
  input  logic         xer_we_i,
  input  logic [W-1:0] xer_wdata_i,
  output logic [W-1:0] result_o,
  output logic [W-1:0] xer_o,
  output logic [3:0]   cr_o
);
  logic      ca_full, ov_full, ca_half, ov_half;
  flags_t    flags;
  cr_field_t cr_q;

  fxu_adder #(.W(W), .HW(HW)) u_adder (
    .a_i       (op_a_i),
    .b_i       (op_b_i),
    .sub_i     (sub_i),
    .sum_o     (result_o),
    .ca_full_o (ca_full),
    .ov_full_o (ov_full),
    .ca_half_o (ca_half),
    .ov_half_o (ov_half)
  );

  fxu_status_sel #(.W(W), .HW(HW)) u_sel (
    .sum_i     (result_o),
    .mode32_i  (mode32_i),
    .ca_full_i (ca_full),
    .ov_full_i (ov_full),
    .ca_half_i (ca_half),
    .ov_half_i (ov_half),
    .flags_o   (flags)
  );

  fxu_state #(.W(W)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flags_i     (flags),
    .status_en_i (status_en_i),
    .rec_i       (rec_i),
    .xer_we_i    (xer_we_i),
    .xer_wdata_i (xer_wdata_i),
    .xer_o       (xer_o),
    .cr_o        (cr_q)
  );

  assign cr_o = cr_q;
endmodule

// File: rtl/fxu_status_unit_chk.sv
module fxu_status_unit_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         status_en_i,
  input logic         rec_i,
  input logic         xer_we_i,
  input logic [W-1:0] xer_wdata_i,
  input logic [W-1:0] xer_o,
  input logic [3:0]   cr_o
);
  AST_XER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_en_i && !xer_we_i) |=> $stable(xer_o)); // R5
  AST_CR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_i |=> $stable(cr_o)); // R8
  AST_SO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xer_o[31] && !xer_we_i) |=> xer_o[31]); // R6
  AST_OV_SETS_SO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_en_i && !xer_we_i) |=> (!xer_o[30] || xer_o[31])); // R6
  AST_CR_ONE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> ($countones(cr_o[3:1]) == 1)); // R7
  AST_CR_SO_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> (cr_o[0] == xer_o[31])); // R7
  AST_XER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xer_we_i |=> (xer_o == $past(xer_wdata_i))); // R9
endmodule

bind fxu_status_unit fxu_status_unit_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .status_en_i (status_en_i),
  .rec_i       (rec_i),
  .xer_we_i    (xer_we_i),
  .xer_wdata_i (xer_wdata_i),
  .xer_o       (xer_o),
  .cr_o        (cr_o)
);

// File: tb/fxu_status_unit_tb.sv
module fxu_status_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] MAX32  = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] ALL32  = 64'h0000_0000_FFFF_FFFF;
  localparam logic [63:0] MAX64  = 64'h7FFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] op_a = '0, op_b = '0, wdata = '0;
  logic        sub = 1'b0, m32 = 1'b0, sen = 1'b0, rec = 1'b0, we = 1'b0;
  logic [63:0] result, xer;
  logic [3:0]  cr;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] exp_xer = '0;
  logic [3:0]  exp_cr  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxu_status_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_a_i(op_a), .op_b_i(op_b), .sub_i(sub),
    .mode32_i(m32), .status_en_i(sen), .rec_i(rec), .xer_we_i(we),
    .xer_wdata_i(wdata), .result_o(result), .xer_o(xer), .cr_o(cr)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] expv);
    n_tests++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  // independent wide-integer model of the requirements
  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic s,
                       input logic mode, output logic [63:0] res, output logic ca,
                       output logic ov, output logic neg, output logic zero);
    logic signed [65:0] ea, eb, r;
    logic [32:0] c32;
    logic [64:0] c64;
    res = s ? (b - a) : (a + b);
    if (mode) begin
      ea = {{34{a[31]}}, a[31:0]};
      eb = {{34{b[31]}}, b[31:0]};
      c32 = {1'b0, a[31:0]} + {1'b0, b[31:0]};
      ca = s ? (b[31:0] >= a[31:0]) : c32[32];
      r  = s ? (eb - ea) : (ea + eb);
      ov = (r != {{34{r[31]}}, r[31:0]});
      neg  = res[31];
      zero = (res[31:0] == 32'd0);
    end else begin
      ea = {{2{a[63]}}, a};
      eb = {{2{b[63]}}, b};
      c64 = {1'b0, a} + {1'b0, b};
      ca = s ? (b >= a) : c64[64];
      r  = s ? (eb - ea) : (ea + eb);
      ov = (r != {{2{r[63]}}, r[63:0]});
      neg  = res[63];
      zero = (res == 64'd0);
    end
  endtask

  // one operation: drive at negedge, check result, clock, check state
  task automatic run_op(input string tag, input logic [63:0] a, input logic [63:0] b,
                        input logic s, input logic mode, input logic en, input logic rc);
    logic [63:0] res;
    logic ca, ov, neg, zero;
    model(a, b, s, mode, res, ca, ov, neg, zero);
    op_a = a; op_b = b; sub = s; m32 = mode; sen = en; rec = rc; we = 1'b0;
    #1;
    chk({tag, " R1 result"}, result, res);
    if (en) begin
      exp_xer[29] = ca;
      exp_xer[30] = ov;
      exp_xer[31] = exp_xer[31] | ov;
    end
    if (rc) exp_cr = {neg, ~neg & ~zero, zero, exp_xer[31]};
    @(posedge clk); @(negedge clk);
    chk({tag, " xer"}, xer, exp_xer);
    chk({tag, " cr"}, {60'd0, cr}, {60'd0, exp_cr});
    sen = 1'b0; rec = 1'b0;
  endtask

  task automatic write_xer(input string tag, input logic [63:0] d, input logic en);
    we = 1'b1; wdata = d; sen = en; rec = 1'b0;
    op_a = MAX64; op_b = 64'd1; sub = 1'b0; m32 = 1'b0;
    exp_xer = d;
    @(posedge clk); @(negedge clk);
    chk({tag, " R9 write"}, xer, exp_xer);
    we = 1'b0; sen = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 xer at reset", xer, 64'd0);
    chk("R10 cr at reset", {60'd0, cr}, 64'd0);
  endtask

  task automatic t_boundary_full;
    run_op("R2 max64+1", MAX64, 64'd1, 1'b0, 1'b0, 1'b1, 1'b1);
    write_xer("R6 clear", 64'd0, 1'b0);
    run_op("R2 all-ones+1", '1, 64'd1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_op("R2 max32+1", MAX32, 64'd1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_op("R2 ffff_ffff+1", ALL32, 64'd1, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_boundary_half;
    write_xer("R6 clear", 64'd0, 1'b0);
    run_op("R3 max32+1", MAX32, 64'd1, 1'b0, 1'b1, 1'b1, 1'b1);
    write_xer("R6 clear", 64'd0, 1'b0);
    run_op("R3 ffff_ffff+1", ALL32, 64'd1, 1'b0, 1'b1, 1'b1, 1'b1);
    run_op("R3 max64+1", MAX64, 64'd1, 1'b0, 1'b1, 1'b1, 1'b1);
    run_op("R3 hi-only", 64'h1234_5678_0000_0000, 64'h1, 1'b0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_subtract;
    write_xer("R6 clear", 64'd0, 1'b0);
    run_op("R4 sub borrow", 64'd5, 64'd3, 1'b1, 1'b0, 1'b1, 1'b1);
    run_op("R4 sub equal", MAX64, MAX64, 1'b1, 1'b0, 1'b1, 1'b1);
    run_op("R4 sub half borrow", 64'h0000_0000_0000_0002, 64'h0000_0001_0000_0001,
           1'b1, 1'b1, 1'b1, 1'b1);
    run_op("R4 sub ovf", 64'h0000_0000_0000_0001, 64'h0000_0000_8000_0000,
           1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_hold;
    write_xer("R5 seed", 64'hA5A5_0000_0000_1234, 1'b0);
    run_op("R5 no status", MAX64, 64'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    run_op("R8 no record", 64'd0, 64'd0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_sticky;
    write_xer("R6 clear", 64'd0, 1'b0);
    run_op("R6 set", MAX32, 64'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op("R6 keep", 64'd1, 64'd1, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R6 so still set", {63'd0, xer[31]}, 64'd1);
    write_xer("R6 R9 clear beats update", 64'd0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_boundary_full();
    t_boundary_half();
    t_subtract();
    t_hold();
    t_sticky();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule